// File: doc/BRIEF.md
# Host Packet Buffer Window

This block gives a byte-wide host bus access to two on-board packet stores of 2048 bytes each. One store holds a frame waiting to be sent. The other holds the last frame that arrived. A single 16-bit host pointer selects the byte. The host loads the pointer one byte at a time. A read of the pointer's offsets returns the received byte count instead of the pointer. A mode register selects which store faces the host. It also holds the start-send and arm-receive commands, and each command clears itself when its operation ends. Only the low 11 bits of the pointer address a store, so any address at or above 2048 wraps back into the store.

On the network side, a valid/ready byte stream drains the send store. It starts at the pointer value held when the send was started and runs through the top byte. An arrival stream with a frame-end flag fills the receive store from address 0 upward. A host write to the board-reset offset returns the pointer, the mode, the count and both state machines to their reset values. The contents of the stores are kept.

The send machine has two states. TX_IDLE moves to TX_SEND when the mode register is written with the send bit set. TX_SEND returns to TX_IDLE when the byte at address 2047 is accepted, when the mode register is written with the send bit clear, or on board reset. The receive machine has three states. RX_IDLE moves to RX_WAIT when the mode register is written with the arm bit set. RX_WAIT moves to RX_FILL on the first byte of a frame that is not also its last. RX_WAIT or RX_FILL returns to RX_IDLE on the frame-end byte, when the mode register is written with the arm bit clear, or on board reset.

Top module: `pktbuf_window`

## Requirements
- R1: A host write to offset 0x10 loads pointer bits [7:0]. A host write to offset 0x11 loads pointer bits [15:8].
- R2: A host read of offset 0x10 returns bits [7:0] of the received byte count, and a read of 0x11 returns bits [15:8]. The pointer is not returned. The count is 0 after reset.
- R3: Mode bit 0 selects which store faces the host. When it is 1, the data port at 0x14 reads and writes the receive store. When it is 0, the data port at 0x15 reads and writes the send store. An access to the port of the store that does not face the host is ignored: a read returns 0, a write changes nothing, and the pointer does not move.
- R4: Each accepted access to a data port advances the pointer by one.
- R5: A store is addressed by the pointer modulo 2048. For example, pointer 0x0801 reaches byte 1.
- R6: Writing the mode register with bit 5 set starts a send. The machine offers bytes from the current pointer address up through address 2047, one byte per accepted valid/ready handshake. The last flag is raised only on the byte at address 2047.
- R7: Mode bit 5 reads back as 1 while a send runs. It reads as 0 once the byte at address 2047 has been accepted.
- R8: Writing the mode register with bit 6 set arms reception. Arriving bytes are written to the receive store from address 0 upward. Bytes that arrive while reception is not armed change neither the store nor the count.
- R9: When the frame-end byte arrives, the count is loaded with the number of bytes in the frame and mode bit 6 reads back 0.
- R10: A read of the mode register at 0x12 returns bits 7 and [4:1] as 0, whatever value was written.
- R11: Any host write to offset 0x17 clears the pointer, the mode, the count and both machines. The contents of the stores are kept.
- R12: Writing the mode register with bit 5 clear while a send runs stops it at once. Writing it with bit 6 clear cancels an armed reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 5 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the same cycle as host_rd |
| net_tx_valid | output | 1 | A send byte is offered |
| net_tx_ready | input | 1 | The network side accepts the offered byte |
| net_tx_data | output | 8 | Send byte |
| net_tx_last | output | 1 | The offered byte is the top byte of the send store |
| net_rx_valid | input | 1 | An arriving byte is present |
| net_rx_data | input | 8 | Arriving byte |
| net_rx_last | input | 1 | The arriving byte ends the frame |

## Verification
Assertions check the following on every cycle: the pointer holds when there is no pointer write, data-port access or board reset; an offered send byte keeps its address until it is accepted; a send ends after its top byte is accepted; the receive store is never written while reception is disarmed; the count changes only at a frame end; and a board reset leaves both machines idle with the pointer at zero. Directed scenarios are needed for the rest: data values through both ports, address wrap, the send byte order and the placement of the last flag, the received byte count including its high byte, ignored accesses on the wrong side, cancellation, and the fact that store contents survive a board reset.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int PTR_W = 16;
    localparam int CNT_W = 16;

    localparam logic [4:0] OFF_PTR_LO = 5'h10;
    localparam logic [4:0] OFF_PTR_HI = 5'h11;
    localparam logic [4:0] OFF_MODE   = 5'h12;
    localparam logic [4:0] OFF_RXPORT = 5'h14;
    localparam logic [4:0] OFF_TXPORT = 5'h15;
    localparam logic [4:0] OFF_BDRST  = 5'h17;

    localparam int MB_SIDE = 0;
    localparam int MB_SEND = 5;
    localparam int MB_ARM  = 6;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_FILL
    } rx_state_t;
endpackage

// File: rtl/pbw_store.sv
module pbw_store #(
    parameter int AW  = 11,
    parameter int DW  = 8,
    parameter int NRD = 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g*DW +: DW] = mem[raddr[g*AW +: AW]];
    end
endmodule

// File: rtl/pbw_host_regs.sv
module pbw_host_regs
    import pbw_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             tx_busy,
    input  logic             rx_busy,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [7:0]       rx_byte,
    input  logic [7:0]       tx_byte,
    output logic [AW-1:0]    buf_addr,
    output logic             soft_rst,
    output logic             mode_wr,
    output logic             mode_send,
    output logic             mode_arm,
    output logic             rx_port_wr,
    output logic             tx_port_wr
);
    logic [PTR_W-1:0] ptr;
    logic             side_rx;
    logic             acc;
    logic             rx_acc;
    logic             tx_acc;

    assign acc        = host_wr | host_rd;
    assign rx_acc     = acc && host_addr == OFF_RXPORT && side_rx;
    assign tx_acc     = acc && host_addr == OFF_TXPORT && !side_rx;
    assign rx_port_wr = rx_acc && host_wr;
    assign tx_port_wr = tx_acc && host_wr;
    assign soft_rst   = host_wr && host_addr == OFF_BDRST;
    assign mode_wr    = host_wr && host_addr == OFF_MODE;
    assign mode_send  = host_wdata[MB_SEND];
    assign mode_arm   = host_wdata[MB_ARM];
    assign buf_addr   = ptr[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            side_rx <= 1'b0;
        end else if (soft_rst) begin
            ptr     <= '0;
            side_rx <= 1'b0;
        end else begin
            if (host_wr && host_addr == OFF_PTR_LO) ptr[7:0]  <= host_wdata;
            if (host_wr && host_addr == OFF_PTR_HI) ptr[15:8] <= host_wdata;
            if (rx_acc || tx_acc) ptr <= ptr + 1'b1;
            if (mode_wr) side_rx <= host_wdata[MB_SIDE];
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        if (host_rd) begin
            unique case (host_addr)
                OFF_PTR_LO: host_rdata = rx_count[7:0];
                OFF_PTR_HI: host_rdata = rx_count[15:8];
                OFF_MODE:   host_rdata = {1'b0, rx_busy, tx_busy, 4'b0000, side_rx};
                OFF_RXPORT: host_rdata = side_rx ? rx_byte : 8'h00;
                OFF_TXPORT: host_rdata = side_rx ? 8'h00 : tx_byte;
                default:    host_rdata = 8'h00;
            endcase
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd) |=> $stable(buf_addr)); // R1
endmodule

// File: rtl/pbw_tx_fsm.sv
module pbw_tx_fsm
    import pbw_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          mode_wr,
    input  logic          mode_send,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    store_byte,
    output logic [AW-1:0] rd_addr,
    output logic          net_tx_valid,
    output logic [7:0]    net_tx_data,
    output logic          net_tx_last,
    input  logic          net_tx_ready,
    output logic          busy
);
    tx_state_t     state, state_nx;
    logic [AW-1:0] addr;
    logic          fire;
    logic          at_top;

    assign at_top  = (addr == {AW{1'b1}});
    assign fire    = (state == TX_SEND) && net_tx_ready;
    assign rd_addr = addr;

    always_comb begin
        state_nx = state;
        if (soft_rst) begin
            state_nx = TX_IDLE;
        end else if (mode_wr) begin
            state_nx = mode_send ? TX_SEND : TX_IDLE;
        end else begin
            unique case (state)
                TX_IDLE: state_nx = TX_IDLE;
                TX_SEND: if (fire && at_top) state_nx = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            addr  <= '0;
        end else begin
            state <= state_nx;
            if (!soft_rst && mode_wr) addr <= start_addr;
            else if (fire && !soft_rst) addr <= addr + 1'b1;
        end
    end

    always_comb begin
        net_tx_valid = 1'b0;
        net_tx_data  = 8'h00;
        net_tx_last  = 1'b0;
        busy         = 1'b0;
        unique case (state)
            TX_IDLE: ;
            TX_SEND: begin
                net_tx_valid = 1'b1;
                net_tx_data  = store_byte;
                net_tx_last  = at_top;
                busy         = 1'b1;
            end
        endcase
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && !net_tx_ready && !mode_wr && !soft_rst)
        |=> (net_tx_valid && $stable(rd_addr))); // R6
    AST_TX_END: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && net_tx_ready && net_tx_last && !mode_wr && !soft_rst)
        |=> !busy); // R7
endmodule

// File: rtl/pbw_rx_fsm.sv
module pbw_rx_fsm
    import pbw_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             mode_wr,
    input  logic             mode_arm,
    input  logic             net_rx_valid,
    input  logic [7:0]       net_rx_data,
    input  logic             net_rx_last,
    output logic             buf_we,
    output logic [AW-1:0]    buf_waddr,
    output logic [7:0]       buf_wdata,
    output logic [CNT_W-1:0] count,
    output logic             busy
);
    rx_state_t        state, state_nx;
    logic [AW-1:0]    waddr;
    logic [CNT_W-1:0] run;
    logic             take;

    always_comb begin
        state_nx = state;
        if (soft_rst) begin
            state_nx = RX_IDLE;
        end else if (mode_wr) begin
            state_nx = mode_arm ? RX_WAIT : RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE: state_nx = RX_IDLE;
                RX_WAIT: if (net_rx_valid) state_nx = net_rx_last ? RX_IDLE : RX_FILL;
                RX_FILL: if (net_rx_valid && net_rx_last) state_nx = RX_IDLE;
                default: state_nx = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            waddr <= '0;
            run   <= '0;
            count <= '0;
        end else begin
            state <= state_nx;
            if (soft_rst) begin
                waddr <= '0;
                run   <= '0;
                count <= '0;
            end else if (mode_wr) begin
                waddr <= '0;
                run   <= '0;
            end else if (take) begin
                waddr <= waddr + 1'b1;
                run   <= run + 1'b1;
                if (net_rx_last) count <= run + 1'b1;
            end
        end
    end

    always_comb begin
        busy = 1'b0;
        take = 1'b0;
        unique case (state)
            RX_IDLE: ;
            RX_WAIT, RX_FILL: begin
                busy = 1'b1;
                take = net_rx_valid && !mode_wr && !soft_rst;
            end
            default: ;
        endcase
    end

    assign buf_we    = take;
    assign buf_waddr = waddr;
    assign buf_wdata = net_rx_data;

    AST_RX_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !buf_we); // R8
    AST_RX_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && net_rx_last) && !soft_rst |=> $stable(count)); // R9
endmodule

// File: rtl/pktbuf_window.sv
module pktbuf_window
    import pbw_pkg::*;
#(
    parameter int BUF_BYTES = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       net_tx_valid,
    input  logic       net_tx_ready,
    output logic [7:0] net_tx_data,
    output logic       net_tx_last,
    input  logic       net_rx_valid,
    input  logic [7:0] net_rx_data,
    input  logic       net_rx_last
);
    localparam int AW = $clog2(BUF_BYTES);

    logic [AW-1:0]    hptr;
    logic             soft_rst, mode_wr, mode_send, mode_arm;
    logic             rx_port_wr, tx_port_wr;
    logic             tx_busy, rx_busy;
    logic [CNT_W-1:0] rx_count;
    logic [AW-1:0]    tx_rd_addr;
    logic [15:0]      tx_rdata;
    logic [7:0]       rx_rdata;
    logic             rx_net_we;
    logic [AW-1:0]    rx_net_addr;
    logic [7:0]       rx_net_data;
    logic             rx_we;
    logic [AW-1:0]    rx_waddr;
    logic [7:0]       rx_wdata;

    pbw_host_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_count(rx_count),
        .rx_byte(rx_rdata), .tx_byte(tx_rdata[7:0]),
        .buf_addr(hptr), .soft_rst(soft_rst), .mode_wr(mode_wr),
        .mode_send(mode_send), .mode_arm(mode_arm),
        .rx_port_wr(rx_port_wr), .tx_port_wr(tx_port_wr)
    );

    pbw_tx_fsm #(.AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .mode_wr(mode_wr), .mode_send(mode_send), .start_addr(hptr),
        .store_byte(tx_rdata[15:8]), .rd_addr(tx_rd_addr),
        .net_tx_valid(net_tx_valid), .net_tx_data(net_tx_data),
        .net_tx_last(net_tx_last), .net_tx_ready(net_tx_ready),
        .busy(tx_busy)
    );

    pbw_rx_fsm #(.AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .mode_wr(mode_wr), .mode_arm(mode_arm),
        .net_rx_valid(net_rx_valid), .net_rx_data(net_rx_data),
        .net_rx_last(net_rx_last),
        .buf_we(rx_net_we), .buf_waddr(rx_net_addr), .buf_wdata(rx_net_data),
        .count(rx_count), .busy(rx_busy)
    );

    pbw_store #(.AW(AW), .DW(8), .NRD(2)) u_tx_store (
        .clk(clk), .we(tx_port_wr), .waddr(hptr), .wdata(host_wdata),
        .raddr({tx_rd_addr, hptr}), .rdata(tx_rdata)
    );

    // Network arrival takes the single write port; a host write in the same cycle is dropped.
    assign rx_we    = rx_net_we | rx_port_wr;
    assign rx_waddr = rx_net_we ? rx_net_addr : hptr;
    assign rx_wdata = rx_net_we ? rx_net_data : host_wdata;

    pbw_store #(.AW(AW), .DW(8), .NRD(1)) u_rx_store (
        .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
        .raddr(hptr), .rdata(rx_rdata)
    );

    AST_BOARD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!tx_busy && !rx_busy && hptr == '0 && rx_count == '0)); // R11
endmodule

// File: tb/test_pktbuf_window.sv
`timescale 1ns/1ps
module test_pktbuf_window;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       net_tx_valid, net_tx_last;
    logic       net_tx_ready = 1'b0;
    logic [7:0] net_tx_data;
    logic       net_rx_valid = 1'b0, net_rx_last = 1'b0;
    logic [7:0] net_rx_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pktbuf_window i_pktbuf_window (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .net_tx_valid(net_tx_valid), .net_tx_ready(net_tx_ready),
        .net_tx_data(net_tx_data), .net_tx_last(net_tx_last),
        .net_rx_valid(net_rx_valid), .net_rx_data(net_rx_data),
        .net_rx_last(net_rx_last)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        hwr(5'h10, p[7:0]);
        hwr(5'h11, p[15:8]);
    endtask

    task automatic rx_frame(input int len, input logic [7:0] key);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            net_rx_valid = 1'b1;
            net_rx_data  = 8'(i) ^ key;
            net_rx_last  = (i == len - 1);
        end
        @(posedge clk); #1;
        net_rx_valid = 1'b0; net_rx_last = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        hrd(5'h10, v); chk("R2 count lo after reset", v, 0);
        hrd(5'h11, v); chk("R2 count hi after reset", v, 0);
        hrd(5'h12, v); chk("R10 mode after reset", v, 0);
        chk("R6 no tx after reset", net_tx_valid, 0);
    endtask

    task automatic t_pointer;
        logic [7:0] v;
        hwr(5'h12, 8'h01);
        set_ptr(16'h0000); hwr(5'h14, 8'h00);
        set_ptr(16'h0200); hwr(5'h14, 8'h3C);
        hwr(5'h14, 8'h3D);
        set_ptr(16'h0200); hrd(5'h14, v); chk("R1 high byte of pointer", v, 8'h3C);
        hrd(5'h14, v); chk("R4 pointer advanced", v, 8'h3D);
        set_ptr(16'h0000); hrd(5'h14, v); chk("R1 byte 0 untouched", v, 8'h00);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        hwr(5'h12, 8'h01);
        set_ptr(16'h0001); hwr(5'h14, 8'h00);
        set_ptr(16'h0801); hwr(5'h14, 8'h77);
        set_ptr(16'h0001); hrd(5'h14, v); chk("R5 wrap 0x801 to 1", v, 8'h77);
        set_ptr(16'hF7FF); hwr(5'h14, 8'h5E);
        set_ptr(16'h07FF); hrd(5'h14, v); chk("R5 wrap high pointer", v, 8'h5E);
    endtask

    task automatic t_side;
        logic [7:0] v;
        hwr(5'h12, 8'h00);
        set_ptr(16'h0010); hwr(5'h15, 8'h11);
        hwr(5'h12, 8'h01);
        set_ptr(16'h0010); hwr(5'h14, 8'h42);
        set_ptr(16'h0010);
        hwr(5'h15, 8'h99);
        hrd(5'h15, v); chk("R3 far-side read gives 0", v, 0);
        hrd(5'h14, v); chk("R3 far-side access keeps pointer", v, 8'h42);
        hwr(5'h12, 8'h00);
        set_ptr(16'h0010); hrd(5'h15, v); chk("R3 far-side write ignored", v, 8'h11);
        hrd(5'h14, v); chk("R3 rx port closed when bit0 clear", v, 0);
    endtask

    task automatic t_send;
        logic [7:0] v;
        int len = 60;
        int start = 2048 - 60;
        bit lastseen = 0;
        net_tx_ready = 1'b0;
        hwr(5'h12, 8'h00);
        set_ptr(16'(start));
        for (int i = 0; i < len; i++) hwr(5'h15, 8'(i * 3 + 1));
        set_ptr(16'(start));
        hwr(5'h12, 8'h20);
        hrd(5'h12, v); chk("R7 send bit set while sending", v, 8'h20);
        @(negedge clk);
        chk("R6 valid held while not ready", net_tx_valid, 1);
        chk("R6 first byte held", net_tx_data, 1);
        net_tx_ready = 1'b1;
        for (int i = 0; i < len; i++) begin
            #1;
            if (net_tx_valid !== 1'b1 || net_tx_data !== 8'(i * 3 + 1) ||
                net_tx_last !== (i == len - 1)) begin
                chk("R6 send byte", {net_tx_valid, net_tx_last, net_tx_data},
                    {1'b1, (i == len - 1), 8'(i * 3 + 1)});
            end
            if (net_tx_last) lastseen = 1;
            @(negedge clk);
        end
        chk("R6 last flagged on top byte", lastseen, 1);
        chk("R6 stream stops after top byte", net_tx_valid, 0);
        net_tx_ready = 1'b0;
        hrd(5'h12, v); chk("R7 send bit cleared", v, 8'h00);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        set_ptr(16'h0100);
        hwr(5'h12, 8'h20);
        @(negedge clk); chk("R12 send running", net_tx_valid, 1);
        hwr(5'h12, 8'h00);
        @(negedge clk); chk("R12 send stopped", net_tx_valid, 0);
        hwr(5'h12, 8'h40);
        hwr(5'h12, 8'h00);
        hrd(5'h12, v); chk("R12 arm cancelled", v, 0);
        rx_frame(3, 8'hC3);
        hrd(5'h10, v); chk("R12 no count after cancel", v, 0);
    endtask

    task automatic t_receive;
        logic [7:0] v;
        hwr(5'h12, 8'h40);
        hrd(5'h12, v); chk("R8 arm bit reads back", v, 8'h40);
        rx_frame(70, 8'h5A);
        hrd(5'h12, v); chk("R9 arm bit cleared at frame end", v, 8'h00);
        hrd(5'h10, v); chk("R9 count lo", v, 70);
        hrd(5'h11, v); chk("R2 count hi", v, 0);
        hwr(5'h12, 8'h01);
        set_ptr(16'h0000);
        for (int i = 0; i < 70; i++) begin
            hrd(5'h14, v);
            if (v !== (8'(i) ^ 8'h5A)) chk("R8 received byte", v, 8'(i) ^ 8'h5A);
        end
        n_chk++;
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        hwr(5'h12, 8'h01);
        rx_frame(5, 8'hEE);
        hrd(5'h10, v); chk("R8 count kept when disarmed", v, 70);
        set_ptr(16'h0000); hrd(5'h14, v); chk("R8 store kept when disarmed", v, 8'h5A);
    endtask

    task automatic t_long;
        logic [7:0] v;
        hwr(5'h12, 8'h40);
        rx_frame(300, 8'h00);
        hrd(5'h10, v); chk("R9 long count lo", v, 300 & 255);
        hrd(5'h11, v); chk("R2 long count hi", v, 1);
        hwr(5'h12, 8'h01);
        set_ptr(16'd299); hrd(5'h14, v); chk("R8 last byte placed", v, 299 & 255);
    endtask

    task automatic t_mode_bits;
        logic [7:0] v;
        hwr(5'h12, 8'h9F);
        hrd(5'h12, v); chk("R10 bits 7 and 4:1 read 0", v, 8'h01);
    endtask

    task automatic t_board_reset;
        logic [7:0] v;
        hwr(5'h12, 8'h01);
        set_ptr(16'h0003); hwr(5'h14, 8'h66);
        hwr(5'h12, 8'h41);
        hwr(5'h17, 8'h00);
        hrd(5'h12, v); chk("R11 mode cleared", v, 0);
        hrd(5'h10, v); chk("R11 count cleared", v, 0);
        hwr(5'h12, 8'h01);
        hrd(5'h14, v); chk("R11 pointer cleared", v, 8'h00);
        set_ptr(16'h0003); hrd(5'h14, v); chk("R11 store kept", v, 8'h66);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_wrap();
        t_side();
        t_send();
        t_abort();
        t_receive();
        t_ignore();
        t_long();
        t_mode_bits();
        t_board_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule